// File: doc/BRIEF.md
# Control-Register Bus Target Responder

This block is the target end of a strobe-and-acknowledge control-register bus. It sits in front of a small register file so that a bus master can be exercised without an external model. The master presents a 16-bit value on a shared input and raises one of four strobes. The strobes select what happens to that value: it can be latched as the address, held as pending write data, committed into the addressed register, or used to read the addressed register back onto the 16-bit output.

The responder answers every strobe with an acknowledge. The acknowledge rises a fixed, parameterised number of clock edges after the strobe's rising edge is sampled. It stays high until the master has released every strobe. A fault-mode parameter suppresses the acknowledge entirely, so that a master's timeout path can be tested. The register file is indexed by the low address bits. Any address at or beyond the register count reads as zero and discards writes.

Top module: `crTarget`

## Requirements
- R1: After reset, ack and dataOut are 0, and every register, the latched address and the pending data are zero, so reading any register returns 0.
- R2: A rising edge on capAddr latches the full 16-bit dataIn as the bus address.
- R3: A rising edge on capData loads dataIn into a pending-data holder. The addressed register keeps its old value until a write strobe.
- R4: A rising edge on wrStrobe copies the pending data into the register selected by the latched address.
- R5: A rising edge on rdStrobe loads the addressed register onto dataOut before ack rises. dataOut then stays stable for as long as ack is high, and changes only because of a read.
- R6: ack rises on the ACK_LAT-th clock edge after the edge that samples the strobe's rise (default ACK_LAT = 2).
- R7: ack stays high while any strobe is high. It falls on the first clock edge that samples all four strobes low.
- R8: A strobe that rises while a transaction is in progress (from the accepted edge until ack has fallen) is ignored: it performs no action and is not replayed later. At most one action is taken per edge.
- R9: An address of NUM_REGS or more reads as 0 and ignores writes. All 16 address bits are compared, so such an address never aliases onto an existing register.
- R10: With NO_ACK = 1 every action is still performed, but ack never rises. The responder becomes idle again once all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 16 | Address or write data from the master |
| capAddr | input | 1 | Strobe: latch dataIn as the address |
| capData | input | 1 | Strobe: latch dataIn as pending data |
| wrStrobe | input | 1 | Strobe: commit pending data to the addressed register |
| rdStrobe | input | 1 | Strobe: drive the addressed register onto dataOut |
| dataOut | output | 16 | Read data, valid while ack is high after a read |
| ack | output | 1 | Acknowledge for the current strobe |

## Verification
The bench goes after the exact acknowledge latency. A responder that is off by one register would ack a cycle early or late, and a master that samples data on ack would then read stale values. It captures data and then reads before the write strobe: a design that commits on capture would show the new value too early. It raises a second strobe while ack is high and then reads back the address. A design that acted on that strobe, or queued it for later, would have moved the address. It also writes to an address that aliases register 1 in its low bits, which would corrupt register 1 in a design that truncates the address. A second instance in no-ack mode checks that actions still land while ack stays low.

// File: rtl/crTargetPkg.sv
package crTargetPkg;

  // One-cycle action pulses from the control FSM to the datapath
  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic commit;
    logic readOut;
  } crAction_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } crState_t;

endpackage

// File: rtl/crTargetCtrl.sv
module crTargetCtrl
  import crTargetPkg::*;
#(
  parameter int ACK_LAT = 2,
  parameter bit NO_ACK  = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      capAddr,
  input  logic      capData,
  input  logic      wrStrobe,
  input  logic      rdStrobe,
  output crAction_t act,
  output logic      ack
);

  localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);

  logic [3:0] strobeNow;
  logic [3:0] strobePrev;
  logic [3:0] strobeRise;
  logic       anyHigh;
  crState_t   state, nextState;
  logic [CNT_W-1:0] latCnt;

  assign strobeNow  = {capAddr, capData, wrStrobe, rdStrobe};
  assign strobeRise = strobeNow & ~strobePrev;
  assign anyHigh    = |strobeNow;

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= '0;
    else       strobePrev <= strobeNow;
  end

  // Fixed priority when several strobes rise together: address, data, write, read
  always_comb begin
    act       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (strobeRise[3])      act.loadAddr = 1'b1;
        else if (strobeRise[2]) act.loadData = 1'b1;
        else if (strobeRise[1]) act.commit   = 1'b1;
        else if (strobeRise[0]) act.readOut  = 1'b1;
        if (|strobeRise) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (NO_ACK) begin
          if (!anyHigh) nextState = ST_IDLE;
        end else if (latCnt == CNT_LAST) begin
          nextState = ST_ACK;
        end
      end
      ST_ACK: begin
        if (!anyHigh) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
      ack    <= 1'b0;
    end else begin
      state  <= nextState;
      latCnt <= (state == ST_WAIT && nextState == ST_WAIT) ? latCnt + 1'b1 : '0;
      ack    <= (nextState == ST_ACK);
    end
  end

endmodule

// File: rtl/crTargetDp.sv
module crTargetDp
  import crTargetPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  crAction_t         act,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int IDX_W = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS);

  logic [DATA_W-1:0] addrReg;
  logic [DATA_W-1:0] pendReg;
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [IDX_W-1:0]  regIdx;
  logic              inRange;
  logic [DATA_W-1:0] readVal;

  assign inRange = ({{(32-DATA_W){1'b0}}, addrReg} < 32'(NUM_REGS));
  assign regIdx  = addrReg[IDX_W-1:0];
  assign readVal = inRange ? regFile[regIdx] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      pendReg <= '0;
      dataOut <= '0;
    end else begin
      if (act.loadAddr) addrReg <= dataIn;
      if (act.loadData) pendReg <= dataIn;
      if (act.readOut)  dataOut <= readVal;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    logic hit;
    assign hit = act.commit && inRange && (regIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)    regFile[g] <= '0;
      else if (hit) regFile[g] <= pendReg;
    end
  end

endmodule

// File: rtl/crTarget.sv
module crTarget
  import crTargetPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ACK_LAT  = 2,
  parameter bit NO_ACK   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              capAddr,
  input  logic              capData,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              ack
);

  crAction_t act;

  crTargetCtrl #(.ACK_LAT(ACK_LAT), .NO_ACK(NO_ACK)) uCtrl (
    .clk(clk), .rstN(rstN),
    .capAddr(capAddr), .capData(capData),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .act(act), .ack(ack)
  );

  crTargetDp #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uDp (
    .clk(clk), .rstN(rstN),
    .act(act), .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/crTargetChecker.sv
module crTargetChecker
  import crTargetPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              capAddr,
  input logic              capData,
  input logic              wrStrobe,
  input logic              rdStrobe,
  input logic              ack,
  input logic [DATA_W-1:0] dataOut,
  input crAction_t         act
);

  logic anyStrobe;
  assign anyStrobe = capAddr | capData | wrStrobe | rdStrobe;

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ack) |-> !$past(anyStrobe));

  assert_read_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ack && $past(ack)) |-> $stable(dataOut));

  assert_out_only_on_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $past(act.readOut));

  assert_single_action_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(act));

  assert_no_action_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (act == '0));

endmodule

bind crTarget crTargetChecker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN),
  .capAddr(capAddr), .capData(capData),
  .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
  .ack(ack), .dataOut(dataOut), .act(act)
);

// File: tb/crTarget_test.sv
module crTarget_test;

  localparam int CLK_PERIOD = 10;
  localparam int ACK_LAT    = 2;

  // op: 0 = address, 1 = data, 2 = write, 3 = read (compare expect)
  localparam int NVEC = 16;
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'h0001, 16'h0000},
    {2'd1, 16'hA5A5, 16'h0000},
    {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'h0000, 16'hA5A5},
    {2'd0, 16'h0007, 16'h0000},
    {2'd1, 16'h1234, 16'h0000},
    {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'h0000, 16'h1234},
    {2'd0, 16'h0009, 16'h0000},
    {2'd1, 16'h5555, 16'h0000},
    {2'd2, 16'h0000, 16'h0000},
    {2'd3, 16'h0000, 16'h0000},
    {2'd0, 16'h0001, 16'h0000},
    {2'd3, 16'h0000, 16'hA5A5},
    {2'd0, 16'h0000, 16'h0000},
    {2'd3, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] dataIn = '0;
  logic        capAddr = 1'b0, capData = 1'b0, wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [15:0] dataOut, naDataOut;
  logic        ack, naAck;

  int checks = 0;
  int errors = 0;
  int naAckSeen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crTarget #(.ACK_LAT(ACK_LAT)) uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .capAddr(capAddr), .capData(capData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .dataOut(dataOut), .ack(ack)
  );

  crTarget #(.ACK_LAT(ACK_LAT), .NO_ACK(1'b1)) uutNoAck (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .capAddr(capAddr), .capData(capData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
    .dataOut(naDataOut), .ack(naAck)
  );

  always @(negedge clk) if (rstN && naAck) naAckSeen++;

  task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setStrobe(input int op, input logic v);
    case (op)
      0: capAddr  = v;
      1: capData  = v;
      2: wrStrobe = v;
      default: rdStrobe = v;
    endcase
  endtask

  // Full transaction: raise strobe, time ack (R6), check read (R5), release, check ack drop (R7)
  task automatic doOp(input int op, input logic [15:0] val, input logic [15:0] expRead);
    int n = 0;
    @(negedge clk);
    dataIn = val;
    setStrobe(op, 1'b1);
    while (!ack && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == ACK_LAT + 1, "R6 ack latency", 16'(n), 16'(ACK_LAT + 1));
    if (op == 3) check(dataOut == expRead, "R5 read data", dataOut, expRead);
    setStrobe(op, 1'b0);
    @(negedge clk);
    check(ack == 1'b0, "R7 ack falls after release", {15'd0, ack}, 16'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ack == 1'b0, "R1 ack in reset", {15'd0, ack}, 16'd0);
    check(dataOut == 16'd0, "R1 dataOut in reset", dataOut, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    doOp(0, 16'h0003, 0);
    doOp(3, 0, 16'h0000);   // R1: register 3 reads zero after reset

    // Table walk: R2 address, R4 commit, R5 read, R9 out-of-range and no alias
    for (int i = 0; i < NVEC; i++) begin
      doOp(int'(VEC[i][33:32]), VEC[i][31:16], VEC[i][15:0]);
    end
    // R10: no-ack instance performed the same reads
    check(naDataOut == 16'h0000, "R10 no-ack read data", naDataOut, 16'h0000);

    // R3: captured data not visible before write
    doOp(0, 16'h0002, 0);
    doOp(1, 16'hBEEF, 0);
    doOp(3, 0, 16'h0000);
    doOp(2, 0, 0);
    doOp(3, 0, 16'hBEEF);   // R4

    // R7: ack held while the strobe stays high
    @(negedge clk);
    dataIn = 16'h1111;
    capData = 1'b1;
    repeat (ACK_LAT + 1) @(negedge clk);
    check(ack == 1'b1, "R7 ack up", {15'd0, ack}, 16'd1);
    // R8: address strobe raised while busy must be ignored
    dataIn = 16'h0005;
    capAddr = 1'b1;
    repeat (4) @(negedge clk);
    check(ack == 1'b1, "R7 ack held while strobe high", {15'd0, ack}, 16'd1);
    capData = 1'b0;
    @(negedge clk);
    check(ack == 1'b1, "R7 ack held while any strobe high", {15'd0, ack}, 16'd1);
    capAddr = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R7 ack drops", {15'd0, ack}, 16'd0);
    repeat (3) @(negedge clk);
    check(ack == 1'b0, "R8 ignored strobe not replayed", {15'd0, ack}, 16'd0);
    doOp(2, 0, 0);
    doOp(3, 0, 16'h1111);   // R8: address still 2, pending data 1111 committed there
    doOp(0, 16'h0005, 0);
    doOp(3, 0, 16'h0000);   // R8: register 5 untouched

    // R10: no-ack instance did the actions but never acked
    check(naDataOut == 16'h0000, "R10 no-ack follows reads", naDataOut, 16'h0000);
    doOp(0, 16'h0002, 0);
    doOp(3, 0, 16'h1111);
    check(naDataOut == 16'h1111, "R10 no-ack write landed", naDataOut, 16'h1111);
    check(naAckSeen == 0, "R10 no-ack never acks", 16'(naAckSeen), 16'd0);

    finishRun();
  end

endmodule